// File: doc/BRIEF.md
# Receive Overhead Bit Port

This block sits behind the receive framer of a T1/E1 line and taps the overhead bits out of the recovered bit stream. It shows them on a one-bit serial data output and marks the data-link bits with an output clock that runs only when needed. The framer's alignment logic supplies a bit strobe, the bit position within the frame, the frame number within the multiframe and the recovered serial bit. The block decodes these to find the overhead bits.

In E1 mode the tapped bits are the five national bits, in bit positions 3 to 7 (counted from 0) of timeslot 0 in frames that do not carry the alignment word. In T1 extended-superframe mode they are the framing-bit positions that carry the facility data link. The data output follows every tapped bit whatever the configuration. The output clock pulses only for the bits that software has marked as data-link carriers: a per-bit mask in E1 mode and a single enable in T1 mode. The block has no notion of a downstream HDLC receiver, so both outputs behave the same whether or not one also consumes the bits. The data output changes only when the output clock is low, so external equipment can sample it on the clock's rising edge.

Top module: `ohx_rx_port`

## Requirements
- R1: While `rstN` is low, and after reset until the first tapped bit, `ohData` is 0 and `ohClk` is 0.
- R2: In E1 mode (`e1Mode`=1), a strobed bit with `bitPos` in 3..7 and `frameNum` bit 0 equal to 1 (a frame without the alignment word) is shown on `ohData` from the cycle after the strobe, whatever `saClkMask` holds.
- R3: In E1 mode, strobed bits in frames with `frameNum` bit 0 equal to 0, and strobed bits at positions outside 3..7, leave `ohData` unchanged and give no `ohClk` pulse.
- R4: In E1 mode, a tapped bit at position 3+k gives an `ohClk` pulse only when `saClkMask[k]` is 1 (bit 0 maps to the first national bit, bit 4 to the last). No pulse is ever given for a bit that was not tapped.
- R5: In T1 mode (`e1Mode`=0), a strobed bit at `bitPos` 0 with `frameNum` even and below 24 is shown on `ohData` from the cycle after the strobe. It gives an `ohClk` pulse only when `fdlClkEn` is 1.
- R6: In T1 mode, strobed bits at other positions, in odd frames, or with `frameNum` 24 or above leave `ohData` unchanged and give no pulse.
- R7: An `ohClk` pulse is high for exactly one clock cycle and starts two cycles after the strobe. `ohData` does not change while `ohClk` is high; it changes only at the edge where `ohClk` falls or while it is low. `bitStrobe` is never high in two consecutive cycles.
- R8: Between tapped bits, `ohData` holds the last tapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| e1Mode | input | 1 | 1 = E1 national bits, 0 = T1 data link |
| bitStrobe | input | 1 | One-cycle mark of a recovered bit |
| bitPos | input | 8 | Position of the bit within its frame |
| frameNum | input | 5 | Frame number within the multiframe |
| rxBit | input | 1 | Recovered serial bit |
| saClkMask | input | 5 | E1 per-national-bit clock enable |
| fdlClkEn | input | 1 | T1 data-link clock enable |
| ohData | output | 1 | Serial overhead data |
| ohClk | output | 1 | Data-link bit clock |

## Verification
On every cycle, the assertions check the pulse shape and the two-cycle lag of `ohClk`, the hold of `ohData` under a high clock and between tapped bits, and that no pulse is given without a tap. Only the bench scenarios can show which positions and frames are tapped in each mode, how the mask and the enable map to individual bits, and the reset values. The bench compares each strobe against a queue of expected data and clock values derived from the position rules.

// File: rtl/ohx_pkg.sv
package ohx_pkg;
  // strobes from the position decoder to the output registers
  typedef struct packed {
    logic capture;  // the current strobed bit is an overhead bit
    logic pulse;    // the current strobed bit is also a data-link bit
  } ohx_strobe_t;
endpackage

// File: rtl/ohx_ctrl.sv
module ohx_ctrl
  import ohx_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int FRM_W     = 5,
  parameter int SA_FIRST  = 3,
  parameter int SA_NUM    = 5,
  parameter int T1_FRAMES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              e1Mode,
  input  logic              bitStrobe,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [FRM_W-1:0]  frameNum,
  input  logic [SA_NUM-1:0] saClkMask,
  input  logic              fdlClkEn,
  output ohx_strobe_t       stb
);
  localparam logic [FRM_W-1:0] T1_LIMIT = FRM_W'(T1_FRAMES);

  logic [SA_NUM-1:0] saHit;
  logic e1Slot, e1ClkSel, e1NonAlign, t1Slot, isOh, clkSel;

  // one comparator per national bit position
  genvar gi;
  generate
    for (gi = 0; gi < SA_NUM; gi++) begin : g_sa
      assign saHit[gi] = (bitPos == POS_W'(SA_FIRST + gi));
    end
  endgenerate

  always_comb begin
    e1Slot     = |saHit;
    e1ClkSel   = |(saHit & saClkMask);
    e1NonAlign = frameNum[0];
    t1Slot     = (bitPos == '0) && !frameNum[0] && (frameNum < T1_LIMIT);
    isOh       = e1Mode ? (e1Slot && e1NonAlign) : t1Slot;
    clkSel     = e1Mode ? e1ClkSel : fdlClkEn;
    stb.capture = bitStrobe && isOh;
    stb.pulse   = bitStrobe && isOh && clkSel;
  end

  // input rule: recovered bits are never strobed back to back (R7)
  assert_strobe_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  // a clock pulse is only requested for a tapped bit (R4)
  assert_pulse_needs_tap_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pulse |-> stb.capture);

  // E1 frames carrying the alignment word are never tapped (R3)
  assert_no_tap_align_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    (e1Mode && !frameNum[0]) |-> !stb.capture);

  // T1 bits past the superframe are never tapped (R6)
  assert_no_tap_past_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!e1Mode && frameNum >= T1_LIMIT) |-> !stb.capture);
endmodule

// File: rtl/ohx_dp.sv
module ohx_dp
  import ohx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBit,
  input  ohx_strobe_t stb,
  output logic        ohData,
  output logic        ohClk
);
  logic clkPend;

  // data updates one edge before the clock rises
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ohData  <= 1'b0;
      clkPend <= 1'b0;
      ohClk   <= 1'b0;
    end else begin
      if (stb.capture) ohData <= rxBit;
      clkPend <= stb.pulse;
      ohClk   <= clkPend;
    end
  end

  // pulse is one cycle wide (R7)
  assert_clk_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    ohClk |=> !ohClk);

  // data is stable while the clock is high (R7)
  assert_data_stable_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    ohClk |-> $stable(ohData));

  // a pulse follows its request by two cycles (R4)
  assert_clk_lag_R4: assert property (@(posedge clk) disable iff (!rstN)
    ohClk |-> $past(stb.pulse, 2));

  // data holds when no bit is tapped (R8)
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(ohData));
endmodule

// File: rtl/ohx_rx_port.sv
module ohx_rx_port
  import ohx_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int FRM_W     = 5,
  parameter int SA_FIRST  = 3,
  parameter int SA_NUM    = 5,
  parameter int T1_FRAMES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              e1Mode,
  input  logic              bitStrobe,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [FRM_W-1:0]  frameNum,
  input  logic              rxBit,
  input  logic [SA_NUM-1:0] saClkMask,
  input  logic              fdlClkEn,
  output logic              ohData,
  output logic              ohClk
);
  ohx_strobe_t stb;

  ohx_ctrl #(
    .POS_W(POS_W), .FRM_W(FRM_W), .SA_FIRST(SA_FIRST),
    .SA_NUM(SA_NUM), .T1_FRAMES(T1_FRAMES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .e1Mode(e1Mode), .bitStrobe(bitStrobe),
    .bitPos(bitPos), .frameNum(frameNum), .saClkMask(saClkMask),
    .fdlClkEn(fdlClkEn), .stb(stb)
  );

  ohx_dp u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .stb(stb),
    .ohData(ohData), .ohClk(ohClk)
  );

  // reset drives both outputs low (R1)
  assert_reset_low_R1: assert property (@(posedge clk)
    !rstN |=> (!ohData && !ohClk));
endmodule

// File: tb/ohx_rx_port_test.sv
module ohx_rx_port_test;
  logic clk = 0, rstN = 0, e1Mode = 1, bitStrobe = 0, rxBit = 0, fdlClkEn = 0;
  logic [7:0] bitPos = '0;
  logic [4:0] frameNum = '0, saClkMask = '0;
  logic ohData, ohClk;

  int checks = 0, errors = 0;
  bit modelData = 0;
  bit done = 0;

  typedef struct { bit data; bit clkOn; string req; } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  ohx_rx_port uut (
    .clk(clk), .rstN(rstN), .e1Mode(e1Mode), .bitStrobe(bitStrobe),
    .bitPos(bitPos), .frameNum(frameNum), .rxBit(rxBit),
    .saClkMask(saClkMask), .fdlClkEn(fdlClkEn), .ohData(ohData), .ohClk(ohClk)
  );

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // driver: computes the expectation from the position rules and pushes it
  task automatic sendBit(input bit e1, input int pos, input int frm, input bit b, input string req);
    item_t it;
    bit tap, clkOn;
    if (e1) begin
      tap   = (pos >= 3 && pos <= 7) && (frm % 2 == 1);
      clkOn = tap && saClkMask[(pos >= 3 && pos <= 7) ? pos - 3 : 0];
    end else begin
      tap   = (pos == 0) && (frm % 2 == 0) && (frm < 24);
      clkOn = tap && fdlClkEn;
    end
    if (tap) modelData = b;
    it.data = modelData; it.clkOn = clkOn; it.req = req;
    @(negedge clk);
    e1Mode = e1; bitPos = 8'(pos); frameNum = 5'(frm); rxBit = b; bitStrobe = 1;
    q.push_back(it);
    @(negedge clk);
    bitStrobe = 0; rxBit = ~b;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops an item for every strobe and compares the outputs
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (bitStrobe) begin
        it = q.pop_front();
        @(negedge clk);
        check(ohData, it.data, it.req, "ohData");
        check(ohClk, 1'b0, "R7", "ohClk before rise");
        @(negedge clk);
        check(ohClk, it.clkOn, it.req, "ohClk");
        check(ohData, it.data, "R7", "ohData under clock");
        @(negedge clk);
        check(ohClk, 1'b0, "R7", "ohClk after pulse");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ohData, 1'b0, "R1", "ohData in reset");
    check(ohClk, 1'b0, "R1", "ohClk in reset");
    rstN = 1;
    repeat (2) @(negedge clk);
    check(ohData, 1'b0, "R1", "ohData after reset");

    // E1 with a mixed mask
    saClkMask = 5'b10101;
    sendBit(1, 3, 1, 1, "R4");
    sendBit(1, 4, 1, 0, "R4");
    sendBit(1, 5, 1, 1, "R2");
    sendBit(1, 5, 0, 0, "R3");  // alignment frame ignored
    sendBit(1, 2, 1, 0, "R3");  // below national bits
    sendBit(1, 8, 1, 0, "R8");  // above national bits, data held
    sendBit(1, 0, 3, 0, "R3");
    sendBit(1, 7, 1, 0, "R4");
    sendBit(1, 6, 3, 1, "R4");
    saClkMask = 5'b00000;
    sendBit(1, 3, 5, 0, "R2");  // unconditional data, no clock
    saClkMask = 5'b11111;
    sendBit(1, 6, 15, 1, "R2");

    // T1 data link
    fdlClkEn = 1;
    sendBit(0, 0, 0, 1, "R5");
    sendBit(0, 0, 1, 0, "R6");  // odd frame
    sendBit(0, 1, 2, 0, "R6");  // not the framing bit
    sendBit(0, 0, 24, 0, "R6"); // beyond the superframe
    sendBit(0, 4, 1, 0, "R6");
    sendBit(0, 0, 22, 0, "R5");
    fdlClkEn = 0;
    sendBit(0, 0, 4, 1, "R5");
    sendBit(0, 3, 5, 0, "R8");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule